// File: doc/BRIEF.md
# Host interface event and command status unit

This block collects the host-interface events that a local microcontroller must notice and presents them in one interrupt status register whose flags are active-low. The host drops command bytes into a small first-in-first-out queue, and the microcontroller drains that queue by reading the command register. A down-counter holds the length of a pending data transfer as the byte count minus one. The unit counts transferred bytes against it and raises a transfer-stop interrupt when the last byte has gone. A decoder event raises a third interrupt. Two further flags mirror whether the data and status transfer engines are running.

Each interrupt is cleared in its own way. The command flag clears itself when the queue becomes empty. The transfer flag is cleared by writing any value to an acknowledge register. The decoder flag is cleared by reading a second status register, which also returns the decoder's status byte.

The microcontroller port is a plain register port. `mc_rdata` is a combinational function of `mc_addr` and the current state. All side effects of a read, such as a queue pop or a flag clear, take place on the rising clock edge at which `mc_rd` is high.

The transfer counter runs a three-state machine:
- **XS_IDLE**: after reset or after a stop. Byte pulses are ignored.
- **XS_ARMED**: entered on any write to either counter register. A byte pulse at a count other than 0 decrements the count. A byte pulse at count 0 moves to XS_DONE. A counter write reloads the register and the machine stays armed.
- **XS_DONE**: lasts one cycle and issues the stop pulse, then the machine returns to XS_IDLE.

Top module: `hif_event_unit`

## Requirements
- R1: After reset, status register bits 0 to 4 read 1, bit 5 (overflow) reads 0, the command queue is empty, and both counter registers read 0.
- R2: Host bytes written with `host_wr` are returned in write order by micro reads of address 0. Each such read removes one byte. The queue holds 8 bytes.
- R3: Status bit 0 (address 1) reads 0 while the queue holds at least one byte and reads 1 when the queue is empty.
- R4: A host write to a full queue is dropped and does not disturb the stored bytes. It sets status bit 5, which then stays 1 until reset.
- R5: A micro read of address 0 while the queue is empty returns 0 and leaves the queue unchanged.
- R6: Address 2 holds counter bits 7:0 and address 3 holds counter bits 11:8 (read bits 7:4 are 0). A write to either address updates only its own bits and puts the counter machine in XS_ARMED.
- R7: In XS_ARMED, each `xfer_byte` pulse decrements the counter. The pulse that arrives while the counter is 0 ends the transfer, and status bit 1 reads 0 from two edges after that pulse. In XS_IDLE, byte pulses leave the counter unchanged.
- R8: A write to address 4 returns status bit 1 to 1. If a stop arrives in the same cycle, the stop wins.
- R9: A `dec_evt` pulse sets status bit 2 to 0. A read of address 5 returns `dec_status` and restores bit 2 to 1. If an event arrives in the same cycle, the event wins.
- R10: Status bit 3 reads the inverse of `data_busy` and status bit 4 reads the inverse of `stat_busy`, each one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Host command byte strobe |
| host_data | input | 8 | Host command byte |
| mc_addr | input | 4 | Micro register address |
| mc_rd | input | 1 | Micro read strobe (carries the side effects) |
| mc_wr | input | 1 | Micro write strobe |
| mc_wdata | input | 8 | Micro write data |
| mc_rdata | output | 8 | Micro read data (combinational) |
| xfer_byte | input | 1 | One pulse per transferred data byte |
| data_busy | input | 1 | Data transfer engine running |
| stat_busy | input | 1 | Status transfer engine running |
| dec_evt | input | 1 | Decoder event pulse |
| dec_status | input | 8 | Decoder status returned at address 5 |

## Verification
The bench builds the unit with its default sizes: an 8-byte queue and a 12-bit counter. With an 8-byte queue, random host and micro traffic reaches both the full and the empty boundary many times within a few hundred operations. Because the counter is loaded through the two register halves, short transfer lengths reach the zero-count stop within a handful of byte pulses. The loads also set both halves independently, so the split across the 8-bit and 4-bit halves is exercised.

// File: rtl/hif_pkg.sv
package hif_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CMD    = 4'd0;
    localparam logic [ADDR_W-1:0] A_ISTAT  = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_ACK    = 4'd4;
    localparam logic [ADDR_W-1:0] A_STATE2 = 4'd5;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_ARMED = 2'd1,
        XS_DONE  = 2'd2
    } xfer_state_e;
endpackage

// File: rtl/hif_cmd_fifo.sv
module hif_cmd_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop_req,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             full, do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop_req && !empty;
    assign head    = empty ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_push) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && full) overflow <= 1'b1;
        end
    end

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_drop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop_req) |=> (full && $stable(wptr)));
    assert_empty_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push) |=> (empty && $stable(rptr)));
endmodule

// File: rtl/hif_xfer_counter.sv
module hif_xfer_counter
    import hif_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int LO_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [LO_W-1:0]  wdata,
    input  logic             byte_pulse,
    output logic [CNT_W-1:0] count,
    output logic             stop
);
    localparam int HI_W = CNT_W - LO_W;

    xfer_state_e      state, state_nx;
    logic [CNT_W-1:0] count_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= XS_IDLE;
            count <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
        end
    end

    always_comb begin
        state_nx = state;
        count_nx = count;
        if (wr_lo || wr_hi) begin
            if (wr_lo) count_nx[LO_W-1:0]     = wdata;
            if (wr_hi) count_nx[CNT_W-1:LO_W] = wdata[HI_W-1:0];
            state_nx = XS_ARMED;
        end else begin
            unique case (state)
                XS_IDLE:  state_nx = XS_IDLE;
                XS_ARMED: if (byte_pulse) begin
                    if (count == '0) state_nx = XS_DONE;
                    else             count_nx = count - 1'b1;
                end
                XS_DONE:  state_nx = XS_IDLE;
                default:  state_nx = XS_IDLE;
            endcase
        end
    end

    always_comb begin
        stop = (state == XS_DONE);
    end

    assert_decrement_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XS_ARMED && byte_pulse && !wr_lo && !wr_hi && count != '0)
        |=> (count == $past(count) - 1'b1));
    assert_stop_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XS_ARMED && byte_pulse && !wr_lo && !wr_hi && count == '0)
        |=> stop);
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == XS_IDLE && !wr_lo && !wr_hi) |=> $stable(count));
endmodule

// File: rtl/hif_flag_bank.sv
module hif_flag_bank (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_pulse,
    input  logic ack_wr,
    input  logic dec_evt,
    input  logic st2_rd,
    input  logic data_busy,
    input  logic stat_busy,
    output logic xfer_n,
    output logic dec_n,
    output logic dunit_n,
    output logic sunit_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_n  <= 1'b1;
            dec_n   <= 1'b1;
            dunit_n <= 1'b1;
            sunit_n <= 1'b1;
        end else begin
            if (stop_pulse)  xfer_n <= 1'b0;
            else if (ack_wr) xfer_n <= 1'b1;
            if (dec_evt)     dec_n  <= 1'b0;
            else if (st2_rd) dec_n  <= 1'b1;
            dunit_n <= !data_busy;
            sunit_n <= !stat_busy;
        end
    end

    assert_stop_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !xfer_n);
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !stop_pulse) |=> xfer_n);
    assert_dec_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_evt |=> !dec_n);
    assert_st2_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st2_rd && !dec_evt) |=> dec_n);
endmodule

// File: rtl/hif_event_unit.sv
module hif_event_unit
    import hif_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int CNT_W      = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic [7:0]  host_data,
    input  logic [3:0]  mc_addr,
    input  logic        mc_rd,
    input  logic        mc_wr,
    input  logic [7:0]  mc_wdata,
    output logic [7:0]  mc_rdata,
    input  logic        xfer_byte,
    input  logic        data_busy,
    input  logic        stat_busy,
    input  logic        dec_evt,
    input  logic [7:0]  dec_status
);
    localparam int LO_W = 8;
    localparam int HI_W = CNT_W - LO_W;

    logic [7:0]       fifo_head;
    logic             fifo_empty, fifo_ovf;
    logic [CNT_W-1:0] count;
    logic             stop;
    logic             xfer_n, dec_n, dunit_n, sunit_n;
    logic             pop_req, wr_lo, wr_hi, ack_wr, st2_rd;

    assign pop_req = mc_rd && (mc_addr == A_CMD);
    assign st2_rd  = mc_rd && (mc_addr == A_STATE2);
    assign wr_lo   = mc_wr && (mc_addr == A_CNT_LO);
    assign wr_hi   = mc_wr && (mc_addr == A_CNT_HI);
    assign ack_wr  = mc_wr && (mc_addr == A_ACK);

    hif_cmd_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(host_wr), .push_data(host_data), .pop_req(pop_req),
        .head(fifo_head), .empty(fifo_empty), .overflow(fifo_ovf)
    );

    hif_xfer_counter #(.CNT_W(CNT_W), .LO_W(LO_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(mc_wdata),
        .byte_pulse(xfer_byte), .count(count), .stop(stop)
    );

    hif_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n),
        .stop_pulse(stop), .ack_wr(ack_wr),
        .dec_evt(dec_evt), .st2_rd(st2_rd),
        .data_busy(data_busy), .stat_busy(stat_busy),
        .xfer_n(xfer_n), .dec_n(dec_n), .dunit_n(dunit_n), .sunit_n(sunit_n)
    );

    always_comb begin
        mc_rdata = '0;
        unique case (mc_addr)
            A_CMD:    mc_rdata = fifo_head;
            A_ISTAT:  mc_rdata = {2'b00, fifo_ovf, sunit_n, dunit_n, dec_n, xfer_n, fifo_empty};
            A_CNT_LO: mc_rdata = count[LO_W-1:0];
            A_CNT_HI: mc_rdata = {{(8-HI_W){1'b0}}, count[CNT_W-1:LO_W]};
            A_STATE2: mc_rdata = dec_status;
            default:  mc_rdata = '0;
        endcase
    end

    assert_cmd_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !pop_req) |=> !fifo_empty);
endmodule

// File: tb/sim_hif_event_unit.sv
module sim_hif_event_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       host_wr = 0, mc_rd = 0, mc_wr = 0;
    logic       xfer_byte = 0, data_busy = 0, stat_busy = 0, dec_evt = 0;
    logic [7:0] host_data = 0, mc_wdata = 0, dec_status = 0, mc_rdata;
    logic [3:0] mc_addr = 0;

    int checks = 0, errors = 0;
    logic [7:0] mq [8];
    int mhead = 0, mcount = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hif_event_unit u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic mwrite(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); mc_addr = a; mc_wdata = d; mc_wr = 1;
        @(negedge clk); mc_wr = 0;
    endtask

    task automatic mread(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); mc_addr = a; mc_rd = 1; #1 d = mc_rdata;
        @(negedge clk); mc_rd = 0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        mc_addr = a; #1 d = mc_rdata;
    endtask

    task automatic hpush(input logic [7:0] d);
        @(negedge clk); host_data = d; host_wr = 1;
        if (mcount < 8) begin mq[(mhead + mcount) % 8] = d; mcount++; end
        @(negedge clk); host_wr = 0;
    endtask

    function automatic logic [7:0] model_pop();
        logic [7:0] v;
        if (mcount == 0) return 8'h00;
        v = mq[mhead]; mhead = (mhead + 1) % 8; mcount--;
        return v;
    endfunction

    task automatic pulse_byte();
        @(negedge clk); xfer_byte = 1;
        @(negedge clk); xfer_byte = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        peek(4'd1, d); check("R1 istat", d, 8'h1f);
        peek(4'd2, d); check("R1 cnt lo", d, 8'h00);
        peek(4'd3, d); check("R1 cnt hi", d, 8'h00);
        // R5 empty read
        mread(4'd0, d); check("R5 empty read", d, 8'h00);
        peek(4'd1, d); check("R5 still empty", d[0], 1'b1);
        // R2 R3 order
        hpush(8'hA1); hpush(8'hB2);
        peek(4'd1, d); check("R3 nonempty flag", d[0], 1'b0);
        mread(4'd0, d); check("R2 first", d, model_pop());
        mread(4'd0, d); check("R2 second", d, model_pop());
        peek(4'd1, d); check("R3 empty flag", d[0], 1'b1);
        // R4 overflow
        for (int i = 0; i < 9; i++) hpush(8'(8'h10 + i));
        peek(4'd1, d); check("R4 overflow set", d[5], 1'b1);
        for (int i = 0; i < 8; i++) begin
            mread(4'd0, d); check("R4 kept bytes", d, model_pop());
        end
        peek(4'd1, d); check("R4 overflow sticky", d[5], 1'b1);
        // R6 counter halves
        mwrite(4'd3, 8'hFA); mwrite(4'd2, 8'h05);
        peek(4'd2, d); check("R6 lo", d, 8'h05);
        peek(4'd3, d); check("R6 hi", d, 8'h0A);
        pulse_byte();
        peek(4'd2, d); check("R7 dec lo wrap", d, 8'h04);
        // R7 stop timing
        mwrite(4'd3, 8'h00); mwrite(4'd2, 8'h02);
        pulse_byte(); pulse_byte();
        peek(4'd2, d); check("R7 at zero", d, 8'h00);
        peek(4'd1, d); check("R7 no stop yet", d[1], 1'b1);
        @(negedge clk); xfer_byte = 1;
        @(negedge clk); xfer_byte = 0;
        peek(4'd1, d); check("R7 stop not yet one edge", d[1], 1'b1);
        @(negedge clk);
        peek(4'd1, d); check("R7 stop flag", d[1], 1'b0);
        pulse_byte();
        peek(4'd2, d); check("R7 idle ignores byte", d, 8'h00);
        // R8 ack
        mwrite(4'd4, 8'h00);
        peek(4'd1, d); check("R8 ack clears", d[1], 1'b1);
        // R9 decoder
        @(negedge clk); dec_evt = 1; @(negedge clk); dec_evt = 0;
        peek(4'd1, d); check("R9 dec set", d[2], 1'b0);
        dec_status = 8'h3C;
        mread(4'd5, d); check("R9 state2 data", d, 8'h3C);
        peek(4'd1, d); check("R9 dec cleared", d[2], 1'b1);
        @(negedge clk); dec_evt = 1; mc_addr = 4'd5; mc_rd = 1;
        @(negedge clk); dec_evt = 0; mc_rd = 0;
        peek(4'd1, d); check("R9 event wins", d[2], 1'b0);
        mread(4'd5, d);
        // R10 busy mirrors
        @(negedge clk); data_busy = 1;
        peek(4'd1, d); check("R10 latency", d[3], 1'b1);
        @(negedge clk);
        peek(4'd1, d); check("R10 data busy", d[4:3], 2'b10);
        stat_busy = 1; data_busy = 0;
        @(negedge clk);
        peek(4'd1, d); check("R10 stat busy", d[4:3], 2'b01);
        stat_busy = 0;
        // random FIFO traffic R2 R3
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 1) == 1) hpush(8'($urandom));
            else begin mread(4'd0, d); check("R2 random pop", d, model_pop()); end
            peek(4'd1, d); check("R3 random flag", d[0], (mcount == 0) ? 1'b1 : 1'b0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule